// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file on a small I/O bus. The bus has a 16-bit port address, an 8-bit data path, and separate read and write strobes. It serves a handful of writable control bits: a soft reset request, a byte-order flag, a disk activity light, a 4-bit system control field and an I/O map type bit. It also answers reads of fixed identity and equipment bytes.

Some writes have side effects and store no data. Writes to two protect ports each emit a one-cycle pulse that flips a write-protect lock in an external non-volatile memory.

Any access to a port with no function for that direction is flagged on a one-cycle decode-error pulse. An undecoded read returns all ones.

The bus decoder sorts each address into one selection: none, special, cpu-config, feature, module-status, led, equipment, protect-1, protect-2, cache-invalidate, keylock, sysctl, cache-id or map-type. Each selection carries its own read-legal and write-legal flags. The block has no sequential control beyond its registers. Every access completes in the cycle after its strobe is sampled.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to port 0x0092 sets `reset_req` from data bit 0 and `endian_le` from data bit 1.
- R2: A read of port 0x0092 returns `endian_le` in bit 1, with all other bits 0.
- R3: Reads of ports 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these ports change no output, change no later read value and raise no decode error.
- R4: Reads return fixed values as follows: port 0x080C returns 0x3C, 0x0810 returns 0x39, 0x0818 returns 0x00 and 0x0823 returns 0x03. A read of 0x0814 returns 0xFF and raises no decode error.
- R5: Data bit 0 of a write to port 0x0808 sets or clears `activity_led`.
- R6: A write to port 0x0810 pulses `lock_pulse_a` for exactly one cycle, and a write to 0x0812 pulses `lock_pulse_b` for exactly one cycle. The data value has no effect.
- R7: A write to port 0x081C stores data bits 3:0. A read of that port returns them in bits 3:0, with bits 7:4 zero.
- R8: A write to port 0x0850 stores data bit 0, drives it on `contig_map` and returns it in bit 0 of a read, with the other bits zero.
- R9: A read of an unmapped port returns 0xFF. A write to an unmapped port changes no state. Either access pulses `decode_err` for one cycle. Unmapped includes writes to 0x080C, 0x0818 and 0x0823, and reads of 0x0808 and 0x0812.
- R10: A write to port 0x0814 changes no output and raises no decode error.
- R11: Every output and every read result is registered. It appears in the cycle after the clock edge that samples the strobe. `bus_rdata` holds its value until the next read.
- R12: Synchronous reset clears every writable bit, every pulse and `bus_rdata` to 0.
- R13: In a cycle with no strobe, `decode_err`, `lock_pulse_a` and `lock_pulse_b` stay low and the control outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per sampled cycle |
| bus_rd | input | 1 | Read strobe, one access per sampled cycle |
| bus_rdata | output | 8 | Registered read data |
| reset_req | output | 1 | Soft reset request level |
| endian_le | output | 1 | Little-endian mode flag |
| contig_map | output | 1 | I/O map type flag |
| activity_led | output | 1 | Disk activity indicator |
| lock_pulse_a | output | 1 | Toggle pulse for protect region 1 |
| lock_pulse_b | output | 1 | Toggle pulse for protect region 2 |
| decode_err | output | 1 | One-cycle pulse on an unmapped access |

## Verification
Every result of this block lands exactly one clock after its strobe is sampled. This covers read data, control levels, lock pulses and the decode-error pulse. The bench drives a strobe at a falling edge and drops it at the next falling edge. It compares all seven output flags, and the read byte when there is one, at that same falling edge, half a period after the capturing rising edge. The pulses are also checked one further cycle later, where they must have returned low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int BUS_ADDR_W = 16;
    localparam int BUS_DATA_W = 8;
    localparam int SYSCTL_W   = 4;

    // Port map
    localparam logic [BUS_ADDR_W-1:0] A_SPECIAL  = 16'h0092;
    localparam logic [BUS_ADDR_W-1:0] A_CPU_CFG  = 16'h0800;
    localparam logic [BUS_ADDR_W-1:0] A_FEATURE  = 16'h0802;
    localparam logic [BUS_ADDR_W-1:0] A_MODSTAT  = 16'h0803;
    localparam logic [BUS_ADDR_W-1:0] A_LED      = 16'h0808;
    localparam logic [BUS_ADDR_W-1:0] A_EQUIP    = 16'h080C;
    localparam logic [BUS_ADDR_W-1:0] A_PROT1    = 16'h0810;
    localparam logic [BUS_ADDR_W-1:0] A_PROT2    = 16'h0812;
    localparam logic [BUS_ADDR_W-1:0] A_L2INV    = 16'h0814;
    localparam logic [BUS_ADDR_W-1:0] A_KEYLOCK  = 16'h0818;
    localparam logic [BUS_ADDR_W-1:0] A_SYSCTL   = 16'h081C;
    localparam logic [BUS_ADDR_W-1:0] A_CACHEID  = 16'h0823;
    localparam logic [BUS_ADDR_W-1:0] A_MAPTYPE  = 16'h0850;

    // Fixed read values
    localparam logic [BUS_DATA_W-1:0] K_CPU_CFG  = 8'hEF;
    localparam logic [BUS_DATA_W-1:0] K_FEATURE  = 8'hAD;
    localparam logic [BUS_DATA_W-1:0] K_MODSTAT  = 8'hE0;
    localparam logic [BUS_DATA_W-1:0] K_EQUIP    = 8'h3C;
    localparam logic [BUS_DATA_W-1:0] K_EXTFEAT  = 8'h39;
    localparam logic [BUS_DATA_W-1:0] K_KEYLOCK  = 8'h00;
    localparam logic [BUS_DATA_W-1:0] K_CACHEID  = 8'h03;
    localparam logic [BUS_DATA_W-1:0] K_FLOAT    = '1;

    typedef enum logic [3:0] {
        PS_NONE,
        PS_SPECIAL,
        PS_CPU_CFG,
        PS_FEATURE,
        PS_MODSTAT,
        PS_LED,
        PS_EQUIP,
        PS_PROT1,
        PS_PROT2,
        PS_L2INV,
        PS_KEYLOCK,
        PS_SYSCTL,
        PS_CACHEID,
        PS_MAPTYPE
    } port_sel_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel,
    output logic              rd_ok,
    output logic              wr_ok
);

    always_comb begin
        case (addr)
            A_SPECIAL: sel = PS_SPECIAL;
            A_CPU_CFG: sel = PS_CPU_CFG;
            A_FEATURE: sel = PS_FEATURE;
            A_MODSTAT: sel = PS_MODSTAT;
            A_LED:     sel = PS_LED;
            A_EQUIP:   sel = PS_EQUIP;
            A_PROT1:   sel = PS_PROT1;
            A_PROT2:   sel = PS_PROT2;
            A_L2INV:   sel = PS_L2INV;
            A_KEYLOCK: sel = PS_KEYLOCK;
            A_SYSCTL:  sel = PS_SYSCTL;
            A_CACHEID: sel = PS_CACHEID;
            A_MAPTYPE: sel = PS_MAPTYPE;
            default:   sel = PS_NONE;
        endcase
    end

    // Per-direction legality of each selection
    always_comb begin
        unique case (sel)
            PS_SPECIAL, PS_CPU_CFG, PS_FEATURE, PS_MODSTAT,
            PS_L2INV, PS_SYSCTL, PS_MAPTYPE: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            PS_EQUIP, PS_KEYLOCK, PS_CACHEID: begin
                rd_ok = 1'b1;
                wr_ok = 1'b0;
            end
            PS_PROT1: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            PS_LED, PS_PROT2: begin
                rd_ok = 1'b0;
                wr_ok = 1'b1;
            end
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
    import sysctl_pkg::*;
#(
    parameter int DATA_W = BUS_DATA_W,
    parameter int CTRL_W = SYSCTL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              endian_le,
    output logic              activity_led,
    output logic              contig_map,
    output logic [CTRL_W-1:0] sysctl,
    output logic              lock_a,
    output logic              lock_b
);

    logic              nx_reset_req;
    logic              nx_endian_le;
    logic              nx_activity_led;
    logic              nx_contig_map;
    logic [CTRL_W-1:0] nx_sysctl;
    logic              nx_lock_a;
    logic              nx_lock_b;

    always_comb begin
        nx_reset_req    = reset_req;
        nx_endian_le    = endian_le;
        nx_activity_led = activity_led;
        nx_contig_map   = contig_map;
        nx_sysctl       = sysctl;
        nx_lock_a       = 1'b0;
        nx_lock_b       = 1'b0;
        if (wr_en) begin
            unique case (sel)
                PS_SPECIAL: begin
                    nx_reset_req = wdata[0];
                    nx_endian_le = wdata[1];
                end
                PS_LED:     nx_activity_led = wdata[0];
                PS_PROT1:   nx_lock_a       = 1'b1;
                PS_PROT2:   nx_lock_b       = 1'b1;
                PS_SYSCTL:  nx_sysctl       = wdata[CTRL_W-1:0];
                PS_MAPTYPE: nx_contig_map   = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req    <= 1'b0;
            endian_le    <= 1'b0;
            activity_led <= 1'b0;
            contig_map   <= 1'b0;
            sysctl       <= '0;
            lock_a       <= 1'b0;
            lock_b       <= 1'b0;
        end else begin
            reset_req    <= nx_reset_req;
            endian_le    <= nx_endian_le;
            activity_led <= nx_activity_led;
            contig_map   <= nx_contig_map;
            sysctl       <= nx_sysctl;
            lock_a       <= nx_lock_a;
            lock_b       <= nx_lock_b;
        end
    end

endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
    import sysctl_pkg::*;
#(
    parameter int DATA_W = BUS_DATA_W,
    parameter int CTRL_W = SYSCTL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_ok,
    input  port_sel_e         sel,
    input  logic              endian_le,
    input  logic              contig_map,
    input  logic [CTRL_W-1:0] sysctl,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = K_FLOAT;
        if (rd_ok) begin
            unique case (sel)
                PS_SPECIAL: begin
                    rd_val    = '0;
                    rd_val[1] = endian_le;
                end
                PS_CPU_CFG: rd_val = K_CPU_CFG;
                PS_FEATURE: rd_val = K_FEATURE;
                PS_MODSTAT: rd_val = K_MODSTAT;
                PS_EQUIP:   rd_val = K_EQUIP;
                PS_PROT1:   rd_val = K_EXTFEAT;
                PS_KEYLOCK: rd_val = K_KEYLOCK;
                PS_CACHEID: rd_val = K_CACHEID;
                PS_SYSCTL: begin
                    rd_val             = '0;
                    rd_val[CTRL_W-1:0] = sysctl;
                end
                PS_MAPTYPE: begin
                    rd_val    = '0;
                    rd_val[0] = contig_map;
                end
                default:    rd_val = K_FLOAT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int CTRL_W = SYSCTL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req,
    output logic              endian_le,
    output logic              contig_map,
    output logic              activity_led,
    output logic              lock_pulse_a,
    output logic              lock_pulse_b,
    output logic              decode_err
);

    port_sel_e         sel;
    logic              rd_ok;
    logic              wr_ok;
    logic [CTRL_W-1:0] sysctl;
    logic              bad_access;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (bus_addr),
        .sel   (sel),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    sysctl_ctrl_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (bus_wr && wr_ok),
        .sel          (sel),
        .wdata        (bus_wdata),
        .reset_req    (reset_req),
        .endian_le    (endian_le),
        .activity_led (activity_led),
        .contig_map   (contig_map),
        .sysctl       (sysctl),
        .lock_a       (lock_pulse_a),
        .lock_b       (lock_pulse_b)
    );

    sysctl_read_mux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_rmux (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (bus_rd),
        .rd_ok      (rd_ok),
        .sel        (sel),
        .endian_le  (endian_le),
        .contig_map (contig_map),
        .sysctl     (sysctl),
        .rdata      (bus_rdata)
    );

    assign bad_access = (bus_rd && !rd_ok) || (bus_wr && !wr_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            decode_err <= 1'b0;
        end else begin
            decode_err <= bad_access;
        end
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              reset_req,
    input logic              endian_le,
    input logic              contig_map,
    input logic              activity_led,
    input logic              lock_pulse_a,
    input logic              lock_pulse_b,
    input logic              decode_err
);

    a_r6_lock_a: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lock_pulse_a == $past(bus_wr && bus_addr == 16'h0810)));

    a_r6_lock_b: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lock_pulse_b == $past(bus_wr && bus_addr == 16'h0812)));

    a_r6_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lock_pulse_a, lock_pulse_b}));

    a_r13_idle_no_err: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_rd) && !$past(bus_wr)) |-> !decode_err);

    a_r13_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_wr)) |->
            ($stable(reset_req) && $stable(endian_le) &&
             $stable(contig_map) && $stable(activity_led)));

    a_r12_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({reset_req, endian_le, contig_map, activity_led,
                         lock_pulse_a, lock_pulse_b, decode_err} == 7'b0 &&
                        bus_rdata == '0));

    a_r3_cpu_cfg: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_rd && bus_addr == 16'h0800)) |-> (bus_rdata == 8'hEF));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_rd)) |-> $stable(bus_rdata));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // Output flag vector order: {reset_req, endian_le, contig_map,
    // activity_led, lock_pulse_a, lock_pulse_b, decode_err}
    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  exp_rd;
        logic [6:0]  exp_fl;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h0092, 8'h00, 8'h00, 7'b0000000, 4'd2},  // R2
        '{1'b1, 1'b0, 16'h0092, 8'h03, 8'h00, 7'b1100000, 4'd1},  // R1
        '{1'b0, 1'b1, 16'h0092, 8'h00, 8'h02, 7'b1100000, 4'd2},  // R2
        '{1'b1, 1'b0, 16'h0092, 8'h02, 8'h00, 7'b0100000, 4'd1},  // R1
        '{1'b0, 1'b1, 16'h0800, 8'h00, 8'hEF, 7'b0100000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0802, 8'h00, 8'hAD, 7'b0100000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0803, 8'h00, 8'hE0, 7'b0100000, 4'd3},  // R3
        '{1'b1, 1'b0, 16'h0800, 8'h55, 8'h00, 7'b0100000, 4'd3},  // R3
        '{1'b1, 1'b0, 16'h0803, 8'h00, 8'h00, 7'b0100000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0800, 8'h00, 8'hEF, 7'b0100000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0803, 8'h00, 8'hE0, 7'b0100000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h080C, 8'h00, 8'h3C, 7'b0100000, 4'd4},  // R4
        '{1'b0, 1'b1, 16'h0810, 8'h00, 8'h39, 7'b0100000, 4'd4},  // R4
        '{1'b0, 1'b1, 16'h0818, 8'h00, 8'h00, 7'b0100000, 4'd4},  // R4
        '{1'b0, 1'b1, 16'h0823, 8'h00, 8'h03, 7'b0100000, 4'd4},  // R4
        '{1'b0, 1'b1, 16'h0814, 8'h00, 8'hFF, 7'b0100000, 4'd4},  // R4
        '{1'b1, 1'b0, 16'h0808, 8'hFF, 8'h00, 7'b0101000, 4'd5},  // R5
        '{1'b1, 1'b0, 16'h0810, 8'h00, 8'h00, 7'b0101100, 4'd6},  // R6
        '{1'b1, 1'b0, 16'h0812, 8'hA5, 8'h00, 7'b0101010, 4'd6},  // R6
        '{1'b1, 1'b0, 16'h081C, 8'hF7, 8'h00, 7'b0101000, 4'd7},  // R7
        '{1'b0, 1'b1, 16'h081C, 8'h00, 8'h07, 7'b0101000, 4'd7},  // R7
        '{1'b1, 1'b0, 16'h0850, 8'hFF, 8'h00, 7'b0111000, 4'd8},  // R8
        '{1'b0, 1'b1, 16'h0850, 8'h00, 8'h01, 7'b0111000, 4'd8},  // R8
        '{1'b0, 1'b1, 16'h1234, 8'h00, 8'hFF, 7'b0111001, 4'd9},  // R9
        '{1'b1, 1'b0, 16'h080C, 8'h00, 8'h00, 7'b0111001, 4'd9},  // R9
        '{1'b0, 1'b1, 16'h0808, 8'h00, 8'hFF, 7'b0111001, 4'd9},  // R9
        '{1'b1, 1'b0, 16'h0814, 8'hFF, 8'h00, 7'b0111000, 4'd10}, // R10
        '{1'b1, 1'b0, 16'h0850, 8'hFE, 8'h00, 7'b0101000, 4'd8},  // R8
        '{1'b1, 1'b0, 16'h0808, 8'h02, 8'h00, 7'b0100000, 4'd5},  // R5
        '{1'b1, 1'b0, 16'h0092, 8'h00, 8'h00, 7'b0000000, 4'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        reset_req, endian_le, contig_map, activity_led;
    logic        lock_pulse_a, lock_pulse_b, decode_err;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    sysctl_regfile dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .reset_req    (reset_req),
        .endian_le    (endian_le),
        .contig_map   (contig_map),
        .activity_led (activity_led),
        .lock_pulse_a (lock_pulse_a),
        .lock_pulse_b (lock_pulse_b),
        .decode_err   (decode_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [6:0] flags();
        return {reset_req, endian_le, contig_map, activity_led,
                lock_pulse_a, lock_pulse_b, decode_err};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Strobe for one sampled edge; returns at the falling edge after it.
    task automatic run_op(input logic w, input logic r, input logic [15:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: state after reset
        chk("R12 flags", {1'b0, flags()}, 8'h00);
        chk("R12 rdata", bus_rdata, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wdata);
            chk($sformatf("R%0d vec %0d flags", VECS[i].req, i), {1'b0, flags()},
                {1'b0, VECS[i].exp_fl});
            if (VECS[i].rd)
                chk($sformatf("R%0d vec %0d rdata", VECS[i].req, i), bus_rdata,
                    VECS[i].exp_rd);
        end

        // R6: pulse is one cycle long and data value does not matter
        run_op(1'b1, 1'b0, 16'h0810, 8'hFF);
        chk("R6 pulse a with ones data", {7'b0, lock_pulse_a}, 8'h01);
        @(negedge clk);
        chk("R6 pulse a dropped", {6'b0, lock_pulse_a, lock_pulse_b}, 8'h00);

        // R9: error pulse ends, unmapped write left state untouched
        run_op(1'b1, 1'b0, 16'h0823, 8'hFF);
        chk("R9 err on write 0x0823", {7'b0, decode_err}, 8'h01);
        @(negedge clk);
        chk("R9 err dropped", {7'b0, decode_err}, 8'h00);
        run_op(1'b0, 1'b1, 16'h0812, 8'h00);
        chk("R9 read 0x0812", bus_rdata, 8'hFF);
        chk("R9 read 0x0812 err", {7'b0, decode_err}, 8'h01);

        // R11: read data holds with no strobe
        run_op(1'b0, 1'b1, 16'h0802, 8'h00);
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 8'hAD);

        // R13: idle cycles keep levels and raise nothing
        run_op(1'b1, 1'b0, 16'h0092, 8'h01);
        run_op(1'b1, 1'b0, 16'h0808, 8'h01);
        repeat (4) @(negedge clk);
        chk("R13 idle flags", {1'b0, flags()}, 8'b0_1001000);

        // R12: reset clears all writable state
        run_op(1'b1, 1'b0, 16'h081C, 8'h0A);
        run_op(1'b1, 1'b0, 16'h0850, 8'h01);
        run_op(1'b0, 1'b1, 16'h081C, 8'h00);
        chk("R7 sysctl before reset", bus_rdata, 8'h0A);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 flags after reset", {1'b0, flags()}, 8'h00);
        chk("R12 rdata after reset", bus_rdata, 8'h00);
        rst = 1'b0;
        run_op(1'b0, 1'b1, 16'h081C, 8'h00);
        chk("R12 sysctl cleared", bus_rdata, 8'h00);
        run_op(1'b0, 1'b1, 16'h0850, 8'h00);
        chk("R12 map type cleared", bus_rdata, 8'h00);

        finish_run();
    end

endmodule